// File: doc/BRIEF.md
# CAN Bus-On Re-entry Sequencer

This block owns the reset-mode flag of a CAN controller and decides when the controller may rejoin the bus after software leaves reset mode. A hardware reset or a bus-off event forces the flag to 1. Software can write the flag to 1 or 0, but an asserted external reset pin blocks any attempt to clear it. When the flag is cleared, the block watches the sampled receive line, one bit per bit-time strobe, and counts bus-free periods. A bus-free period is eleven recessive bits in a row.

The number of bus-free periods needed before bus-on depends on what caused the most recent entry into reset mode. After a controller bus-off, 128 periods are needed. After a hardware reset or a software-requested reset, one period is enough. When the count is reached, the block raises a one-clock bus-on pulse and a bus-on level. The level stays high until reset mode is entered again. Bit timing, destuffing, frame decoding and error counting all happen outside this block.

Top module: `canbus_reentry_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `reset_mode` is 1, `bus_on` is 0, `bus_on_pulse` is 0 and `busy` is 0.
- R2: A `bus_off_evt` pulse makes `reset_mode` 1 and `bus_on` 0 in the next cycle.
- R3: A software write of 0 (`cpu_wr`=1, `cpu_wdata`=0) while `ext_rst_pin` is 1 is ignored. `reset_mode` stays 1 and `busy` stays 0.
- R4: A software write of 0 while `reset_mode` is 1 and `ext_rst_pin` is 0 makes `reset_mode` 0 and `busy` 1 in the next cycle.
- R5: A recessive bit is `rx_bit`=1 and a dominant bit is `rx_bit`=0. `rx_bit` counts only in cycles where `bit_tick` is 1 and `busy` is 1. One bus-free period is 11 consecutive counted recessive bits.
- R6: When the last entry into reset mode came from hardware reset or a software write of 1, bus-on follows the first completed bus-free period.
- R7: When the last entry into reset mode came from `bus_off_evt`, bus-on follows the 128th completed bus-free period. After 127 periods, `bus_on` is still 0.
- R8: A dominant bit restarts the recessive run at zero, but bus-free periods already completed are kept. Each new period needs a fresh run of 11 recessive bits.
- R9: The reset cause is recorded only when `reset_mode` goes from 0 to 1. A software write of 1 while `reset_mode` is already 1 does not change the required count.
- R10: Entering reset mode while `busy` is 1 ends the wait (`busy` becomes 0) and discards the recessive run and the completed periods. The next wait starts again from zero.
- R11: `bus_on_pulse` is high for exactly one clock, in the cycle after the strobe that completes the required count. `bus_on` rises in that same cycle and then holds until reset mode is entered again.
- R12: A `bus_off_evt` in the same cycle as a software write of 0 keeps `reset_mode` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bit_tick | input | 1 | One-clock strobe marking a sampled bit |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| ext_rst_pin | input | 1 | External reset pin level; 1 blocks clearing reset mode |
| bus_off_evt | input | 1 | One-clock bus-off event |
| cpu_wr | input | 1 | Software write strobe to the reset-mode flag |
| cpu_wdata | input | 1 | Value written to the reset-mode flag |
| reset_mode | output | 1 | Reset-mode flag, readable by software |
| bus_on | output | 1 | Bus-on level |
| bus_on_pulse | output | 1 | One-clock pulse when bus-on is reached |
| busy | output | 1 | High while waiting for bus-free periods |

## Verification
The bench builds the block with its default parameters: 11 bits per bus-free period, a short wait of one period and a long wait of 128 periods. With these values, the full 128-period recovery after bus-off fits in a few thousand clocks. The bench can therefore check the exact period at which bus-on appears, the state one period before it, a dominant bit in the middle of the long wait, and an abort part-way through a wait. A behavioural model counts recessive bits and periods with plain integers and is compared with every output on every clock.

// File: rtl/canre_pkg.sv
package canre_pkg;
  typedef enum logic {CAUSE_LOCAL = 1'b0, CAUSE_BUSOFF = 1'b1} cause_e;

  // number of bus-free periods required for a given reset cause
  function automatic int periods_needed(cause_e c, int short_n, int long_n);
    return (c == CAUSE_BUSOFF) ? long_n : short_n;
  endfunction

  // true when one more completed period reaches the target
  function automatic logic target_reached(int done_so_far, int target);
    return (done_so_far + 1) == target;
  endfunction
endpackage

// File: rtl/canre_mode_ctrl.sv
module canre_mode_ctrl
  import canre_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bus_off_evt,
  input  logic   ext_rst_pin,
  input  logic   cpu_wr,
  input  logic   cpu_wdata,
  output logic   rm_q,
  output cause_e cause_q,
  output logic   enter_evt,
  output logic   clear_evt
);
  logic set_req, clr_req;

  // setting always wins over clearing
  assign set_req   = bus_off_evt | (cpu_wr & cpu_wdata);
  assign clr_req   = cpu_wr & ~cpu_wdata & ~ext_rst_pin & ~set_req;
  assign enter_evt = set_req & ~rm_q;
  assign clear_evt = clr_req & rm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rm_q    <= 1'b1;
      cause_q <= CAUSE_LOCAL;
    end else if (enter_evt) begin
      rm_q    <= 1'b1;
      cause_q <= bus_off_evt ? CAUSE_BUSOFF : CAUSE_LOCAL;
    end else if (clear_evt) begin
      rm_q    <= 1'b0;
    end
  end
endmodule

// File: rtl/canre_idle_run.sv
module canre_idle_run #(
  parameter int IDLE_BITS = 11,
  localparam int RUN_W    = $clog2(IDLE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic             bit_tick,
  input  logic             rx_bit,
  output logic [RUN_W-1:0] run_q,
  output logic             free_evt
);
  logic last_bit;

  assign last_bit = (run_q == RUN_W'(IDLE_BITS - 1));
  assign free_evt = active & ~restart & bit_tick & rx_bit & last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (restart) begin
      run_q <= '0;
    end else if (active && bit_tick) begin
      if (!rx_bit || last_bit) run_q <= '0;
      else                     run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/canre_free_count.sv
module canre_free_count
  import canre_pkg::*;
#(
  parameter int SHORT_WAIT = 1,
  parameter int LONG_WAIT  = 128,
  localparam int OCC_W     = $clog2(LONG_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             free_evt,
  input  cause_e           cause,
  output logic [OCC_W-1:0] occ_q,
  output logic             done_evt
);
  int target;

  assign target   = periods_needed(cause, SHORT_WAIT, LONG_WAIT);
  assign done_evt = free_evt & target_reached(int'(occ_q), target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  occ_q <= '0;
    else if (restart)            occ_q <= '0;
    else if (done_evt)           occ_q <= '0;
    else if (free_evt)           occ_q <= occ_q + 1'b1;
  end
endmodule

// File: rtl/canbus_reentry_seq.sv
module canbus_reentry_seq
  import canre_pkg::*;
#(
  parameter int IDLE_BITS  = 11,
  parameter int SHORT_WAIT = 1,
  parameter int LONG_WAIT  = 128,
  localparam int RUN_W     = $clog2(IDLE_BITS + 1),
  localparam int OCC_W     = $clog2(LONG_WAIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic ext_rst_pin,
  input  logic bus_off_evt,
  input  logic cpu_wr,
  input  logic cpu_wdata,
  output logic reset_mode,
  output logic bus_on,
  output logic bus_on_pulse,
  output logic busy
);
  // named internal events, observed by the bound checker
  logic             enter_evt, clear_evt, free_evt, done_evt, restart;
  cause_e           cause_q;
  logic [RUN_W-1:0] run_cnt;
  logic [OCC_W-1:0] occ_cnt;
  logic             busy_q, on_q, pulse_q;

  assign restart = enter_evt | clear_evt;

  canre_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .bus_off_evt(bus_off_evt), .ext_rst_pin(ext_rst_pin),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .rm_q(reset_mode), .cause_q(cause_q),
    .enter_evt(enter_evt), .clear_evt(clear_evt)
  );

  canre_idle_run #(.IDLE_BITS(IDLE_BITS)) u_run (
    .clk(clk), .rst_n(rst_n), .active(busy_q), .restart(restart),
    .bit_tick(bit_tick), .rx_bit(rx_bit), .run_q(run_cnt), .free_evt(free_evt)
  );

  canre_free_count #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u_occ (
    .clk(clk), .rst_n(rst_n), .restart(restart), .free_evt(free_evt),
    .cause(cause_q), .occ_q(occ_cnt), .done_evt(done_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      on_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= done_evt;
      if (enter_evt) begin
        busy_q <= 1'b0;
        on_q   <= 1'b0;
      end else if (clear_evt) begin
        busy_q <= 1'b1;
      end else if (done_evt) begin
        busy_q <= 1'b0;
        on_q   <= 1'b1;
      end
    end
  end

  assign busy         = busy_q;
  assign bus_on       = on_q;
  assign bus_on_pulse = pulse_q;
endmodule

// File: rtl/canre_checker.sv
module canre_checker #(
  parameter int IDLE_BITS = 11,
  localparam int RUN_W    = $clog2(IDLE_BITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             rx_bit,
  input logic             ext_rst_pin,
  input logic             bus_off_evt,
  input logic             reset_mode,
  input logic             bus_on,
  input logic             bus_on_pulse,
  input logic             busy,
  input logic             free_evt,
  input logic             done_evt,
  input logic [RUN_W-1:0] run_cnt
);
  a_r2_busoff_forces_mode: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_evt |=> (reset_mode && !bus_on));

  a_r3_pin_blocks_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rst_pin && reset_mode) |=> reset_mode);

  a_r4_busy_only_outside_reset: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!reset_mode && !bus_on));

  a_r5_period_needs_recessive_tick: assert property (@(posedge clk) disable iff (!rst_n)
    free_evt |-> (busy && bit_tick && rx_bit));

  a_r8_dominant_restarts_run: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_tick && !rx_bit) |=> (run_cnt == '0));

  a_r11_pulse_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    bus_on_pulse |=> !bus_on_pulse);

  a_r11_pulse_marks_rise: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (bus_on_pulse && bus_on && !busy));

  a_r11_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_on && !reset_mode) |=> (bus_on || reset_mode));
endmodule

bind canbus_reentry_seq canre_checker #(.IDLE_BITS(IDLE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
  .ext_rst_pin(ext_rst_pin), .bus_off_evt(bus_off_evt), .reset_mode(reset_mode),
  .bus_on(bus_on), .bus_on_pulse(bus_on_pulse), .busy(busy), .free_evt(free_evt),
  .done_evt(done_evt), .run_cnt(run_cnt)
);

// File: tb/canbus_reentry_seq_test.sv
module canbus_reentry_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, rx_bit = 1'b1, ext_rst_pin = 1'b0;
  logic bus_off_evt = 1'b0, cpu_wr = 1'b0, cpu_wdata = 1'b0;
  logic reset_mode, bus_on, bus_on_pulse, busy;

  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  canbus_reentry_seq uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .ext_rst_pin(ext_rst_pin), .bus_off_evt(bus_off_evt), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .reset_mode(reset_mode), .bus_on(bus_on),
    .bus_on_pulse(bus_on_pulse), .busy(busy)
  );

  // behavioural reference: integers, updated on the same edges as the design
  int m_rm = 1, m_from_busoff = 0, m_waiting = 0, m_run = 0, m_done = 0;
  int m_on = 0, m_pulse = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rm = 1; m_from_busoff = 0; m_waiting = 0; m_run = 0; m_done = 0;
      m_on = 0; m_pulse = 0;
    end else begin
      m_pulse = 0;
      if ((bus_off_evt || (cpu_wr && cpu_wdata)) && m_rm == 0) begin
        m_rm = 1; m_from_busoff = bus_off_evt ? 1 : 0;
        m_waiting = 0; m_run = 0; m_done = 0; m_on = 0;
      end else if (bus_off_evt || (cpu_wr && cpu_wdata)) begin
        // already in reset mode: nothing changes
      end else if (cpu_wr && !cpu_wdata && !ext_rst_pin && m_rm == 1) begin
        m_rm = 0; m_waiting = 1; m_run = 0; m_done = 0;
      end else if (m_waiting == 1 && bit_tick) begin
        if (!rx_bit) m_run = 0;
        else begin
          m_run++;
          if (m_run == 11) begin
            m_run = 0;
            m_done++;
            if (m_done == (m_from_busoff ? 128 : 1)) begin
              m_on = 1; m_pulse = 1; m_waiting = 0; m_done = 0;
            end
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2 reset_mode vs model", int'(reset_mode), m_rm);
      chk("R4 busy vs model", int'(busy), m_waiting);
      chk("R6 bus_on vs model", int'(bus_on), m_on);
      chk("R11 bus_on_pulse vs model", int'(bus_on_pulse), m_pulse);
    end
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  logic saw_pulse;

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(logic v);
    bit_tick = 1'b1; rx_bit = v;
    @(negedge clk);
    saw_pulse = bus_on_pulse;
    bit_tick = 1'b0; rx_bit = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_run(int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic write_rm(logic v);
    cpu_wr = 1'b1; cpu_wdata = v;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_wdata = 1'b0;
  endtask

  task automatic pulse_busoff();
    bus_off_evt = 1'b1;
    @(negedge clk);
    bus_off_evt = 1'b0;
  endtask

  initial begin
    idle(3);
    chk("R1 reset_mode in reset", int'(reset_mode), 1);
    chk("R1 bus_on in reset", int'(bus_on), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset_mode after reset", int'(reset_mode), 1);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 pulse after reset", int'(bus_on_pulse), 0);

    // R3: pin held, clear ignored
    ext_rst_pin = 1'b1;
    write_rm(1'b0);
    chk("R3 reset_mode held by pin", int'(reset_mode), 1);
    chk("R3 busy stays low", int'(busy), 0);
    ext_rst_pin = 1'b0;
    write_rm(1'b0);
    chk("R4 reset_mode cleared", int'(reset_mode), 0);
    chk("R4 busy raised", int'(busy), 1);

    // R8 / R5 / R6 / R11: short wait after hardware reset
    send_run(10);
    send_bit(1'b0);
    send_run(10);
    chk("R8 dominant restarts run", int'(bus_on), 0);
    rx_bit = 1'b1;
    idle(20);
    chk("R5 no strobe no progress", int'(bus_on), 0);
    send_bit(1'b1);
    chk("R11 pulse seen on completing strobe", int'(saw_pulse), 1);
    chk("R6 bus_on after one period", int'(bus_on), 1);
    chk("R11 pulse lasts one clock", int'(bus_on_pulse), 0);
    idle(10);
    chk("R11 bus_on holds", int'(bus_on), 1);

    // R2 / R9 / R7: long wait after bus-off
    pulse_busoff();
    chk("R2 reset_mode set by bus-off", int'(reset_mode), 1);
    chk("R2 bus_on dropped", int'(bus_on), 0);
    write_rm(1'b1);
    write_rm(1'b0);
    for (int p = 0; p < 127; p++) begin
      if (p == 64) begin
        send_run(5);
        send_bit(1'b0);
      end
      send_run(11);
    end
    chk("R9 cause kept, not on after 127", int'(bus_on), 0);
    chk("R7 still busy after 127", int'(busy), 1);
    send_run(10);
    chk("R8 period needs fresh run", int'(bus_on), 0);
    send_bit(1'b1);
    chk("R7 on after 128 periods", int'(bus_on), 1);
    chk("R11 pulse on long wait", int'(saw_pulse), 1);

    // R10: abort during wait
    pulse_busoff();
    write_rm(1'b0);
    send_run(33);
    send_run(5);
    write_rm(1'b1);
    chk("R10 busy dropped on abort", int'(busy), 0);
    chk("R10 reset_mode set on abort", int'(reset_mode), 1);
    write_rm(1'b0);
    send_run(6);
    chk("R10 run discarded", int'(bus_on), 0);
    send_run(5);
    chk("R10 fresh short wait completes", int'(bus_on), 1);

    // R12: bus-off wins over same-cycle clear
    pulse_busoff();
    bus_off_evt = 1'b1; cpu_wr = 1'b1; cpu_wdata = 1'b0;
    @(negedge clk);
    bus_off_evt = 1'b0; cpu_wr = 1'b0;
    chk("R12 reset_mode stays set", int'(reset_mode), 1);
    chk("R12 busy stays low", int'(busy), 0);
    idle(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule